// File: doc/BRIEF.md
# Adaptive Peaking and Step Fader

This block is the last stage of a luma sharpening path. Every clock it receives a five-sample window of luma whose centre sample is the original luma, already delayed to line up with the other inputs. It also receives two contour (second-derivative) signals with different bandwidths, a step-improved luma from the edge sharpener, and the local signal envelope. It produces one sharpened luma sample.

Two candidate outputs are formed. The peaked candidate is the centre sample plus a cored and scaled contour. Its gain falls as the envelope rises, so large swings get less peaking. The step candidate is the step-improved luma. A step detector built from the outer taps measures how large and how steep the local transition is. Its output, scaled by the steepness setting, sets the fade between the two candidates. Fine detail is therefore peaked and large edges are step-improved.

A noise level acting at the same time lowers the effective steepness toward zero and raises the coring toward its maximum, so noisy pictures are sharpened less. The result is clamped to the luma range.

Top module: `sc_peak_fader`

## Requirements
- R1: While `rst_n` is low, `luma_out` is 0.
- R2: `luma_out` reflects the inputs presented two rising clock edges earlier. After one edge it still shows the previous result.
- R3: The contour used for peaking is `contour_nar` when `wide_sel` is 0 and `contour_wide` when `wide_sel` is 1.
- R4: Coring threshold `thr = floor(ce*228/64)`, where `ce` is the effective coring setting (0..63, so at most 224, about 22 % of contour full scale 1023). A selected contour with magnitude below `thr` becomes 0; otherwise it passes unchanged.
- R5: Peaking gain `pe = floor(peak_set*(1024-envelope)/1024)`. The peaked value is `tap2 + floor(cored*pe/64)`, where tap k is `luma_taps[10k+9:10k]`. A peaking setting of 0 disables peaking.
- R6: A larger envelope never gives more peaking. With envelope 0 the gain equals `peak_set`.
- R7: Noise weight `k = noise_lvl + (noise_lvl>>5)` (0..64). Effective steepness is `se = floor(steep_set*(64-k)/64)`. Effective coring is `ce = core_set + floor((63-core_set)*k/64)`. A noise level of 0 changes neither; 63 gives `se=0` and `ce=63`.
- R8: Step detector `det = min(floor(|tap3+tap4-tap0-tap1|/4), 63)`.
- R9: Fade weight `w = floor(det*se/64)`. The blend is `floor((peaked*(64-w) + step_luma*w)/64)`.
- R10: The blend is clamped to 0..1023, with no wraparound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| luma_taps | input | 50 | Five 10-bit luma samples; tap k at bits 10k+9:10k, tap 2 is the delayed original |
| contour_nar | input | 11 | Narrow-band contour, signed |
| contour_wide | input | 11 | Wide-band contour, signed |
| step_luma | input | 10 | Step-improved luma |
| envelope | input | 10 | Local signal envelope |
| peak_set | input | 6 | Peaking setting, 0 = 0 %, 63 = 100 % |
| steep_set | input | 6 | Steepness setting, 0 = 0 %, 63 = 100 % |
| core_set | input | 6 | Coring setting, 0 = 0 %, 63 = 100 % |
| noise_lvl | input | 6 | Noise-driven feature reduction, 0 = none, 63 = full |
| wide_sel | input | 1 | Contour select for peaking: 0 narrow, 1 wide |
| luma_out | output | 10 | Sharpened luma |

## Verification
Every internal value ends up in one output sample two edges later, so a wrong gain, threshold or weight shows as a wrong `luma_out` on the first affected sample. A stuck stage register shows up in the sample after it. The vectors are chosen so that each control acts on its own: flat windows make the fade weight zero and isolate peaking and coring, and zero peaking isolates the fade. A fault in one term therefore moves the output by a known amount and cannot be hidden by another term. Values just below and at the coring threshold, and inputs that overdrive both clamp limits, expose off-by-one and wraparound faults.

// File: rtl/sc_pkg.sv
package sc_pkg;
  // Maximum coring level as a percentage of contour full scale
  localparam int CORE_PCT = 22;

  function automatic int iabs(input int x);
    return (x < 0) ? -x : x;
  endfunction
endpackage

// File: rtl/sc_gain_ctrl.sv
module sc_gain_ctrl
  import sc_pkg::*;
#(
  parameter int YW = 10,
  parameter int CW = 11,
  parameter int SW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] peak_set,
  input  logic [SW-1:0] steep_set,
  input  logic [SW-1:0] core_set,
  input  logic [SW-1:0] noise_lvl,
  input  logic [YW-1:0] envelope,
  output logic [SW-1:0] steep_eff,
  output logic [CW-2:0] core_thr,
  output logic [SW-1:0] peak_eff
);
  localparam int SMAX    = (1 << SW) - 1;
  localparam int SONE    = 1 << SW;
  localparam int EONE    = 1 << YW;
  localparam int CFULL   = (1 << (CW - 1)) - 1;
  localparam int CMUL    = (CFULL * CORE_PCT * SONE) / (100 * SMAX);
  localparam int THR_MAX = (SMAX * CMUL) >> SW;

  int k_w;
  int core_e;

  always_comb begin
    // noise weight spans 0..SONE so that full noise removes all steepness
    k_w       = int'(noise_lvl) + (int'(noise_lvl) >> (SW - 1));
    steep_eff = SW'((int'(steep_set) * (SONE - k_w)) >> SW);
    core_e    = int'(core_set) + (((SMAX - int'(core_set)) * k_w) >> SW);
    core_thr  = (CW-1)'((core_e * CMUL) >> SW);
    peak_eff  = SW'((int'(peak_set) * (EONE - int'(envelope))) >> YW);
  end

  // R7
  noise_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (noise_lvl == '0) |-> (steep_eff == steep_set));
  // R7
  noise_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (noise_lvl == SW'(SMAX)) |-> (steep_eff == '0 && core_thr == (CW-1)'(THR_MAX)));
  // R6
  env_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (envelope == '0) |-> (peak_eff == peak_set));
endmodule

// File: rtl/sc_contour_core.sv
module sc_contour_core
  import sc_pkg::*;
#(
  parameter int CW = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wide_sel,
  input  logic signed [CW-1:0] contour_nar,
  input  logic signed [CW-1:0] contour_wide,
  input  logic        [CW-2:0] core_thr,
  output logic signed [CW-1:0] cored
);
  logic signed [CW-1:0] picked;
  int                   mag;

  always_comb begin
    picked = wide_sel ? contour_wide : contour_nar;
    mag    = iabs(int'(picked));
    cored  = (mag < int'(core_thr)) ? '0 : picked;
  end

  // R4
  core_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cored != '0) |-> (iabs(int'(cored)) >= int'(core_thr)));
  // R3
  sel_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_thr == '0) |-> (cored == (wide_sel ? contour_wide : contour_nar)));
endmodule

// File: rtl/sc_step_detect.sv
module sc_step_detect
  import sc_pkg::*;
#(
  parameter int YW     = 10,
  parameter int SW     = 6,
  parameter int DET_SH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [YW-1:0] tap0,
  input  logic [YW-1:0] tap1,
  input  logic [YW-1:0] tap3,
  input  logic [YW-1:0] tap4,
  input  logic [SW-1:0] steep_eff,
  output logic [SW-1:0] fade_w
);
  localparam int SMAX = (1 << SW) - 1;

  int            band;
  int            scaled;
  logic [SW-1:0] det;

  always_comb begin
    // smoothed first difference: grows with both edge height and edge slope
    band   = (int'(tap3) + int'(tap4)) - (int'(tap0) + int'(tap1));
    scaled = iabs(band) >> DET_SH;
    det    = (scaled > SMAX) ? SW'(SMAX) : SW'(scaled);
    fade_w = SW'((int'(det) * int'(steep_eff)) >> SW);
  end

  // R8
  det_clip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iabs((int'(tap3) + int'(tap4)) - (int'(tap0) + int'(tap1))) >= (SMAX << DET_SH))
      |-> (det == SW'(SMAX)));
  // R9
  no_steep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (steep_eff == '0) |-> (fade_w == '0));
endmodule

// File: rtl/sc_fade_out.sv
module sc_fade_out #(
  parameter int YW = 10,
  parameter int CW = 11,
  parameter int SW = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic        [YW-1:0] center,
  input  logic        [YW-1:0] step_y,
  input  logic signed [CW-1:0] cored,
  input  logic        [SW-1:0] peak_eff,
  input  logic        [SW-1:0] fade_w,
  output logic        [YW-1:0] luma_out
);
  localparam int SONE = 1 << SW;
  localparam int YMAX = (1 << YW) - 1;

  int            corr;
  int            peaked;
  int            mix;
  logic [YW-1:0] out_d;
  logic [YW-1:0] out_q;

  always_comb begin
    corr   = (int'(cored) * int'(peak_eff)) >>> SW;
    peaked = int'(center) + corr;
    mix    = (peaked * (SONE - int'(fade_w)) + int'(step_y) * int'(fade_w)) >>> SW;
    if (mix < 0)         out_d = '0;
    else if (mix > YMAX) out_d = YW'(YMAX);
    else                 out_d = YW'(mix);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= out_d;
  end

  assign luma_out = out_q;

  // R5
  pass_orig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fade_w == '0 && peak_eff == '0) |=> (luma_out == $past(center)));
  // R9
  full_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fade_w == '0 && cored == '0) |=> (luma_out == $past(center)));
endmodule

// File: rtl/sc_peak_fader.sv
module sc_peak_fader #(
  parameter int YW     = 10,
  parameter int CW     = 11,
  parameter int SW     = 6,
  parameter int NTAP   = 5,
  parameter int DET_SH = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NTAP*YW-1:0]     luma_taps,
  input  logic signed [CW-1:0]   contour_nar,
  input  logic signed [CW-1:0]   contour_wide,
  input  logic [YW-1:0]          step_luma,
  input  logic [YW-1:0]          envelope,
  input  logic [SW-1:0]          peak_set,
  input  logic [SW-1:0]          steep_set,
  input  logic [SW-1:0]          core_set,
  input  logic [SW-1:0]          noise_lvl,
  input  logic                   wide_sel,
  output logic [YW-1:0]          luma_out
);
  localparam int MID = NTAP / 2;

  typedef struct packed {
    logic        [YW-1:0] center;
    logic        [YW-1:0] step_y;
    logic signed [CW-1:0] cored;
    logic        [SW-1:0] peak_eff;
    logic        [SW-1:0] fade_w;
  } stage_t;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  logic [YW-1:0] tap [NTAP];

  for (genvar g = 0; g < NTAP; g++) begin : g_tap
    assign tap[g] = luma_taps[g*YW +: YW];
  end

  logic [SW-1:0]        steep_eff;
  logic [SW-1:0]        peak_eff;
  logic [CW-2:0]        core_thr;
  logic signed [CW-1:0] cored;
  logic [SW-1:0]        fade_w;

  sc_gain_ctrl #(.YW(YW), .CW(CW), .SW(SW)) i_gain (
    .clk(clk), .rst_n(rst_sn),
    .peak_set(peak_set), .steep_set(steep_set), .core_set(core_set),
    .noise_lvl(noise_lvl), .envelope(envelope),
    .steep_eff(steep_eff), .core_thr(core_thr), .peak_eff(peak_eff)
  );

  sc_contour_core #(.CW(CW)) i_core (
    .clk(clk), .rst_n(rst_sn), .wide_sel(wide_sel),
    .contour_nar(contour_nar), .contour_wide(contour_wide),
    .core_thr(core_thr), .cored(cored)
  );

  sc_step_detect #(.YW(YW), .SW(SW), .DET_SH(DET_SH)) i_det (
    .clk(clk), .rst_n(rst_sn),
    .tap0(tap[MID-2]), .tap1(tap[MID-1]), .tap3(tap[MID+1]), .tap4(tap[MID+2]),
    .steep_eff(steep_eff), .fade_w(fade_w)
  );

  stage_t s1_d;
  stage_t s1_q;

  always_comb begin
    s1_d.center   = tap[MID];
    s1_d.step_y   = step_luma;
    s1_d.cored    = cored;
    s1_d.peak_eff = peak_eff;
    s1_d.fade_w   = fade_w;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) s1_q <= '0;
    else         s1_q <= s1_d;
  end

  sc_fade_out #(.YW(YW), .CW(CW), .SW(SW)) i_fade (
    .clk(clk), .rst_n(rst_sn),
    .center(s1_q.center), .step_y(s1_q.step_y), .cored(s1_q.cored),
    .peak_eff(s1_q.peak_eff), .fade_w(s1_q.fade_w),
    .luma_out(luma_out)
  );

  // R3
  nar_route_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (!wide_sel && core_thr == '0) |=> (s1_q.cored == $past(contour_nar)));
  // R1
  reset_zero_chk: assert property (@(posedge clk)
    (!rst_n) |-> (luma_out == '0));
endmodule

// File: tb/test_sc_peak_fader.sv
module test_sc_peak_fader;
  localparam int CLK_NS = 10;

  typedef struct packed {
    logic [3:0]         req;
    logic [49:0]        taps;
    logic signed [10:0] nar;
    logic signed [10:0] wide;
    logic [9:0]         stp;
    logic [9:0]         env;
    logic [5:0]         pk;
    logic [5:0]         st;
    logic [5:0]         cr;
    logic [5:0]         nz;
    logic               sel;
  } vec_t;

  localparam logic [49:0] F500  = {5{10'd500}};
  localparam logic [49:0] F1000 = {5{10'd1000}};
  localparam logic [49:0] F10   = {5{10'd10}};
  localparam logic [49:0] BIG   = {10'd900, 10'd900, 10'd500, 10'd100, 10'd100};
  localparam logic [49:0] SML   = {10'd520, 10'd520, 10'd500, 10'd480, 10'd480};
  localparam int NV = 14;

  localparam vec_t VEC [NV] = '{
    '{4'd3,  F500,  11'sd100,  -11'sd300, 10'd0,    10'd0,   6'd63, 6'd0,  6'd0,  6'd0,  1'b0}, // R3 narrow
    '{4'd3,  F500,  11'sd100,  -11'sd300, 10'd0,    10'd0,   6'd63, 6'd0,  6'd0,  6'd0,  1'b1}, // R3 wide
    '{4'd4,  F500,  11'sd200,  11'sd0,    10'd0,    10'd0,   6'd63, 6'd0,  6'd63, 6'd0,  1'b0}, // R4 below thr
    '{4'd4,  F500,  11'sd224,  11'sd0,    10'd0,    10'd0,   6'd63, 6'd0,  6'd63, 6'd0,  1'b0}, // R4 at thr
    '{4'd4,  F500,  -11'sd223, 11'sd0,    10'd0,    10'd0,   6'd63, 6'd0,  6'd63, 6'd0,  1'b0}, // R4 negative
    '{4'd5,  F500,  11'sd100,  11'sd0,    10'd0,    10'd512, 6'd63, 6'd0,  6'd0,  6'd0,  1'b0}, // R5 half env
    '{4'd6,  F500,  11'sd200,  11'sd0,    10'd0,    10'd900, 6'd63, 6'd0,  6'd0,  6'd0,  1'b0}, // R6 big env
    '{4'd8,  BIG,   11'sd0,    11'sd0,    10'd1000, 10'd0,   6'd0,  6'd63, 6'd0,  6'd0,  1'b0}, // R8 clip
    '{4'd9,  SML,   11'sd0,    11'sd0,    10'd800,  10'd0,   6'd0,  6'd63, 6'd0,  6'd0,  1'b0}, // R9 partial
    '{4'd7,  BIG,   11'sd0,    11'sd0,    10'd1000, 10'd0,   6'd0,  6'd63, 6'd0,  6'd63, 1'b0}, // R7 full noise
    '{4'd7,  BIG,   11'sd0,    11'sd0,    10'd1000, 10'd0,   6'd0,  6'd63, 6'd0,  6'd32, 1'b0}, // R7 half noise
    '{4'd7,  F500,  11'sd200,  11'sd0,    10'd0,    10'd0,   6'd63, 6'd0,  6'd0,  6'd63, 1'b0}, // R7 coring raise
    '{4'd10, F1000, 11'sd1000, 11'sd0,    10'd0,    10'd0,   6'd63, 6'd0,  6'd0,  6'd0,  1'b0}, // R10 top
    '{4'd10, F10,   -11'sd1000, 11'sd0,   10'd0,    10'd0,   6'd63, 6'd0,  6'd0,  6'd0,  1'b0}  // R10 bottom
  };

  logic               clk = 1'b0;
  logic               rst_n;
  logic [49:0]        luma_taps;
  logic signed [10:0] contour_nar;
  logic signed [10:0] contour_wide;
  logic [9:0]         step_luma;
  logic [9:0]         envelope;
  logic [5:0]         peak_set;
  logic [5:0]         steep_set;
  logic [5:0]         core_set;
  logic [5:0]         noise_lvl;
  logic               wide_sel;
  logic [9:0]         luma_out;

  int total = 0;
  int bad   = 0;

  always #(CLK_NS/2) clk = ~clk;

  sc_peak_fader i_sc_peak_fader (
    .clk(clk), .rst_n(rst_n), .luma_taps(luma_taps),
    .contour_nar(contour_nar), .contour_wide(contour_wide),
    .step_luma(step_luma), .envelope(envelope),
    .peak_set(peak_set), .steep_set(steep_set), .core_set(core_set),
    .noise_lvl(noise_lvl), .wide_sel(wide_sel), .luma_out(luma_out)
  );

  // expected value straight from the requirement formulas
  function automatic int model(input vec_t v);
    int t [5];
    int k, se, ce, thr, pe, c, cd, peaked, det, w, mix;
    for (int i = 0; i < 5; i++) t[i] = int'(v.taps[i*10 +: 10]);
    k   = int'(v.nz) + (int'(v.nz) / 32);
    se  = (int'(v.st) * (64 - k)) / 64;
    ce  = int'(v.cr) + ((63 - int'(v.cr)) * k) / 64;
    thr = (ce * 228) / 64;
    pe  = (int'(v.pk) * (1024 - int'(v.env))) / 1024;
    c   = v.sel ? int'(v.wide) : int'(v.nar);
    cd  = ((c < 0 ? -c : c) < thr) ? 0 : c;
    peaked = t[2] + ((cd * pe) >>> 6);
    det = t[3] + t[4] - t[0] - t[1];
    det = (det < 0 ? -det : det) / 4;
    if (det > 63) det = 63;
    w   = (det * se) / 64;
    mix = (peaked * (64 - w) + int'(v.stp) * w) >>> 6;
    if (mix < 0) mix = 0;
    if (mix > 1023) mix = 1023;
    return mix;
  endfunction

  task automatic drive(input vec_t v);
    luma_taps    = v.taps;
    contour_nar  = v.nar;
    contour_wide = v.wide;
    step_luma    = v.stp;
    envelope     = v.env;
    peak_set     = v.pk;
    steep_set    = v.st;
    core_set     = v.cr;
    noise_lvl    = v.nz;
    wide_sel     = v.sel;
  endtask

  task automatic check(input int got, input int exp, input string req);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    drive(VEC[0]);
    repeat (3) @(negedge clk);
    check(int'(luma_out), 0, "R1 reset output");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // table walk: drive at a falling edge, result after two rising edges
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(negedge clk);
      @(negedge clk);
      check(int'(luma_out), model(VEC[i]), $sformatf("R%0d vector %0d", VEC[i].req, i));
    end

    // R2 latency: one edge after a change the old result remains
    drive(VEC[0]);
    repeat (3) @(negedge clk);
    drive(VEC[12]);
    @(negedge clk);
    check(int'(luma_out), model(VEC[0]), "R2 one edge");
    @(negedge clk);
    check(int'(luma_out), model(VEC[12]), "R2 two edges");

    // R6 monotonic: more envelope, no more peaking
    begin
      vec_t a;
      int o_lo, o_hi;
      a = VEC[6];
      a.env = 10'd0;
      drive(a);
      repeat (2) @(negedge clk);
      o_lo = int'(luma_out);
      check(o_lo, model(a), "R6 envelope zero");
      a.env = 10'd1000;
      drive(a);
      repeat (2) @(negedge clk);
      o_hi = int'(luma_out);
      check(o_hi, model(a), "R6 envelope high");
      check(int'(o_hi <= o_lo), 1, "R6 monotonic");
      // R5 zero peaking setting leaves tap 2
      a.pk = 6'd0;
      drive(a);
      repeat (2) @(negedge clk);
      check(int'(luma_out), 500, "R5 peaking off");
    end

    // R1 asynchronous reset mid-stream
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(int'(luma_out), 0, "R1 async reset");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule